// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block collects eight interrupt requests and decides which one the CPU services next. Six request flags arrive ready-made from logic outside the block: two external pins whose flags are kept elsewhere, three timer overflows and a serial port event. The two remaining sources are external pins that the block handles itself. For these two pins it synchronizes the pin and detects falling edges or low levels. It also holds their control register, which can be read, written as a whole byte, or set and cleared one bit at a time.

Each source has an enable and a priority bit. There is also a global enable. High-priority requests are served ahead of low-priority ones, and a fixed polling order decides between requests on the same level. When a request wins, the block raises a one-cycle take strobe together with the vector address of the source. It then records the level now in service. A return pulse from the CPU releases the most recently entered level, so a high-priority request can interrupt a low-priority routine but never the reverse.

Top module: `dual_level_irq_ctrl`

## Requirements
- R1: After reset, `take_o` is 0, `svc_lvl_o` is 00, and the extra control register reads 00h.
- R2: Source index i (0 ext-A, 1 timer A, 2 ext-B, 3 timer B, 4 serial, 5 timer C, 6 pin 2, 7 pin 3) is served with vector 03h + 8·i, so the vectors run 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h and 3Bh. The vector is presented on `vec_o` in the cycle in which `take_o` is high.
- R3: When several enabled requests share a priority level, the lowest index wins.
- R4: `ien_i[i]` for i = 0..5 enables source i, and `ien_i[7]` is a global enable; while `ien_i[7]` is 0, no request is taken.
- R5: `svc_lvl_o[0]` marks that a low-level routine is active and `svc_lvl_o[1]` marks that a high-level routine is active. A high-priority request is taken while only the low level is active. Nothing is taken while the high level is active, and no low-priority request is taken while any level is active.
- R6: A cycle with `reti_i` high clears the highest set bit of `svc_lvl_o` and produces no take.
- R7: The extra control register reads back on `xr_rdata_o`. Its bits from 7 down to 0 are: pin-3 priority, pin-3 enable, pin-3 flag, pin-3 edge mode, then pin-2 priority, pin-2 enable, pin-2 flag, pin-2 edge mode. A byte write replaces the whole register.
- R8: A bit write with `xr_bit_sel_i` = n loads `xr_bit_val_i` into bit n and leaves the other bits unchanged. A byte write takes precedence over a bit write in the same cycle.
- R9: In edge mode (mode bit 1), a falling edge on the synchronized pin sets the flag. Taking that source clears the flag. A pin that stays low does not set the flag again. Software may write the flag.
- R10: In level mode (mode bit 0), the flag equals the inverted synchronized pin, and it is taken again after each return for as long as the pin stays low.
- R11: If a new falling edge is detected in the same cycle in which the source is taken, the flag stays set, and the source is taken once more after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req_i | input | 6 | Request flags of sources 0..5 |
| src_pri_i | input | 6 | Priority bits of sources 0..5 (1 = high) |
| ien_i | input | 8 | Bits 0..5 are the source enables, bit 7 is the global enable |
| ext2_n_i | input | 1 | External pin 2, active low |
| ext3_n_i | input | 1 | External pin 3, active low |
| xr_wr_i | input | 1 | Byte write strobe for the extra control register |
| xr_wdata_i | input | 8 | Byte write data |
| xr_bit_wr_i | input | 1 | Single-bit write strobe |
| xr_bit_sel_i | input | 3 | Bit index for a single-bit write |
| xr_bit_val_i | input | 1 | Value for a single-bit write |
| xr_rdata_o | output | 8 | Extra control register contents |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | Take-interrupt strobe, one cycle |
| vec_o | output | 8 | Vector address of the taken source |
| svc_lvl_o | output | 2 | Active levels: bit 0 low, bit 1 high |

## Verification
The clash that matters most is a pin-2 flag being set by a new falling edge in the same cycle in which the service clears it. The bench sets up this clash by keeping the global enable off while a first edge sets the flag. It then times a second pin pulse so that its edge detection falls on the exact edge at which the global enable, switched on one cycle earlier, lets the take happen. The flag must still read 1 after the take, and the scoreboard must then see a second 33h vector after the return. A second same-cycle case is a return arriving while a request is pending. That cycle must produce no take, and the request must be served in the next cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC        = 8;
    localparam int IDXW        = $clog2(NSRC);
    localparam int XSRC_FIRST  = 6;
    localparam int NXCH        = NSRC - XSRC_FIRST;
    localparam logic [7:0] VEC_BASE = 8'h03;
    localparam logic [7:0] VEC_STEP = 8'h08;

    // one nibble of the extra control register, MSB first
    typedef struct packed {
        logic pri;
        logic en;
        logic flag;
        logic trig_edge;
    } xchan_t;

    typedef struct packed {
        logic            valid;
        logic            hi;
        logic [IDXW-1:0] idx;
    } pick_t;

    function automatic logic [7:0] vec_of(input logic [IDXW-1:0] i);
        return VEC_BASE + 8'(i) * VEC_STEP;
    endfunction

endpackage

// File: rtl/irqc_xchan.sv
module irqc_xchan
    import irqc_pkg::*;
#(
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_n,
    input  logic [3:0] wr_mask,
    input  logic [3:0] wr_val,
    input  logic       svc_clr,
    output xchan_t     cfg_o
);

    logic [SYNC_LEN-1:0] sync_q;
    logic                prev_q;
    logic                pin_s;
    logic                fall;
    xchan_t              reg_q;
    xchan_t              nxt;
    logic [3:0]          raw;

    assign pin_s = sync_q[SYNC_LEN-1];
    assign fall  = prev_q & ~pin_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], pin_n};
            prev_q <= pin_s;
        end
    end

    always_comb begin
        raw = reg_q;
        raw = (raw & ~wr_mask) | (wr_val & wr_mask);
        nxt = xchan_t'(raw);
        if (reg_q.trig_edge) begin
            if (svc_clr) nxt.flag = 1'b0;
            if (fall)    nxt.flag = 1'b1;   // new edge beats service clear
        end else begin
            nxt.flag = ~pin_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else     reg_q <= nxt;
    end

    assign cfg_o = reg_q;

    // R9
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_q.trig_edge && fall) |=> reg_q.flag);

    // R10
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_q.trig_edge |=> (reg_q.flag == ~$past(pin_s)));

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] pri,
    input  logic [1:0]      svc,
    input  logic            hold,
    output pick_t           pick_o
);

    logic [NSRC-1:0] hi_req;
    logic [NSRC-1:0] lo_req;
    logic [IDXW-1:0] hi_idx;
    logic [IDXW-1:0] lo_idx;

    always_comb begin
        hi_req = req & pri;
        lo_req = req & ~pri;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hi_req[i]) hi_idx = IDXW'(i);
            if (lo_req[i]) lo_idx = IDXW'(i);
        end
        pick_o = '0;
        if (!hold && !svc[1]) begin
            if (|hi_req) begin
                pick_o.valid = 1'b1;
                pick_o.hi    = 1'b1;
                pick_o.idx   = hi_idx;
            end else if (|lo_req && !svc[0]) begin
                pick_o.valid = 1'b1;
                pick_o.idx   = lo_idx;
            end
        end
    end

endmodule

// File: rtl/irqc_svc.sv
module irqc_svc (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       take_hi,
    input  logic       reti,
    output logic [1:0] svc_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_o <= 2'b00;
        end else begin
            if (reti) begin
                if (svc_o[1]) svc_o[1] <= 1'b0;
                else          svc_o[0] <= 1'b0;
            end
            if (take) svc_o[take_hi] <= 1'b1;
        end
    end

    // R6
    pop_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && svc_o == 2'b11) |=> (svc_o == 2'b01));

    // R6
    pop_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && svc_o == 2'b01) |=> (svc_o == 2'b00));

endmodule

// File: rtl/dual_level_irq_ctrl.sv
module dual_level_irq_ctrl
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] src_req_i,
    input  logic [5:0] src_pri_i,
    input  logic [7:0] ien_i,
    input  logic       ext2_n_i,
    input  logic       ext3_n_i,
    input  logic       xr_wr_i,
    input  logic [7:0] xr_wdata_i,
    input  logic       xr_bit_wr_i,
    input  logic [2:0] xr_bit_sel_i,
    input  logic       xr_bit_val_i,
    output logic [7:0] xr_rdata_o,
    input  logic       reti_i,
    output logic       take_o,
    output logic [7:0] vec_o,
    output logic [1:0] svc_lvl_o
);

    logic [7:0]      wr_mask;
    logic [7:0]      wr_val;
    logic [NXCH-1:0] xpin_n;
    xchan_t          xcfg [NXCH];
    logic [NSRC-1:0] req_raw;
    logic [NSRC-1:0] en_all;
    logic [NSRC-1:0] en_req;
    logic [NSRC-1:0] pri_all;
    pick_t           pick;
    logic            take_q;
    logic [7:0]      vec_q;

    assign xpin_n = {ext3_n_i, ext2_n_i};

    always_comb begin
        wr_mask = 8'h00;
        wr_val  = {8{xr_bit_val_i}};
        if (xr_wr_i) begin
            wr_mask = 8'hFF;
            wr_val  = xr_wdata_i;
        end else if (xr_bit_wr_i) begin
            wr_mask = 8'h01 << xr_bit_sel_i;
        end
    end

    for (genvar g = 0; g < NXCH; g++) begin : g_xch
        irqc_xchan #(.SYNC_LEN(2)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .pin_n   (xpin_n[g]),
            .wr_mask (wr_mask[4*g +: 4]),
            .wr_val  (wr_val[4*g +: 4]),
            .svc_clr (pick.valid && pick.idx == IDXW'(XSRC_FIRST + g)),
            .cfg_o   (xcfg[g])
        );
        assign req_raw[XSRC_FIRST + g] = xcfg[g].flag;
        assign en_all[XSRC_FIRST + g]  = xcfg[g].en;
        assign pri_all[XSRC_FIRST + g] = xcfg[g].pri;
    end

    assign req_raw[XSRC_FIRST-1:0] = src_req_i;
    assign en_all[XSRC_FIRST-1:0]  = ien_i[XSRC_FIRST-1:0];
    assign pri_all[XSRC_FIRST-1:0] = src_pri_i;
    assign en_req = req_raw & en_all & {NSRC{ien_i[7]}};

    irqc_pick u_pick (
        .req    (en_req),
        .pri    (pri_all),
        .svc    (svc_lvl_o),
        .hold   (reti_i),
        .pick_o (pick)
    );

    irqc_svc u_svc (
        .clk     (clk),
        .rst     (rst),
        .take    (pick.valid),
        .take_hi (pick.hi),
        .reti    (reti_i),
        .svc_o   (svc_lvl_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            vec_q  <= 8'h00;
        end else begin
            take_q <= pick.valid;
            if (pick.valid) vec_q <= vec_of(pick.idx);
        end
    end

    assign take_o     = take_q;
    assign vec_o      = vec_q;
    assign xr_rdata_o = {xcfg[1], xcfg[0]};

    // R4
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(ien_i[7]));

    // R5
    nest_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !$past(svc_lvl_o[1]));

    // R6
    reti_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reti_i) |-> !take_o);

    // R3
    pick_req_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> en_req[pick.idx]);

endmodule

// File: tb/dual_level_irq_ctrl_test.sv
module dual_level_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] src_req_i;
    logic [5:0] src_pri_i;
    logic [7:0] ien_i;
    logic       ext2_n_i;
    logic       ext3_n_i;
    logic       xr_wr_i;
    logic [7:0] xr_wdata_i;
    logic       xr_bit_wr_i;
    logic [2:0] xr_bit_sel_i;
    logic       xr_bit_val_i;
    logic [7:0] xr_rdata_o;
    logic       reti_i;
    logic       take_o;
    logic [7:0] vec_o;
    logic [1:0] svc_lvl_o;

    int chk_cnt = 0;
    int err_cnt = 0;
    logic [7:0] exp_q[$];
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_level_irq_ctrl uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_vec(input logic [7:0] v);
        exp_q.push_back(v);
    endtask

    // R6: return cycle must not take anything
    task automatic reti_pulse();
        @(negedge clk) reti_i = 1'b1;
        @(negedge clk) reti_i = 1'b0;
        chk(take_o == 1'b0, "R6 no take in return cycle", take_o, 0);
    endtask

    task automatic byte_wr(input logic [7:0] d);
        @(negedge clk) begin xr_wr_i = 1'b1; xr_wdata_i = d; end
        @(negedge clk) xr_wr_i = 1'b0;
    endtask

    task automatic bit_wr(input logic [2:0] n, input logic v);
        @(negedge clk) begin xr_bit_wr_i = 1'b1; xr_bit_sel_i = n; xr_bit_val_i = v; end
        @(negedge clk) xr_bit_wr_i = 1'b0;
    endtask

    // scoreboard monitor (R2 vectors and order)
    always @(negedge clk) begin
        if (!rst && take_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected take", vec_o, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(vec_o == e, "R2 vector", vec_o, e);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", chk_cnt, err_cnt);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; src_req_i = '0; src_pri_i = '0; ien_i = '0;
        ext2_n_i = 1'b1; ext3_n_i = 1'b1; xr_wr_i = 1'b0; xr_wdata_i = '0;
        xr_bit_wr_i = 1'b0; xr_bit_sel_i = '0; xr_bit_val_i = 1'b0; reti_i = 1'b0;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R1
        chk(take_o == 1'b0, "R1 take after reset", take_o, 0);
        chk(svc_lvl_o == 2'b00, "R1 svc after reset", svc_lvl_o, 0);
        chk(xr_rdata_o == 8'h00, "R1 register after reset", xr_rdata_o, 0);

        // R3: timer A and serial together on low level
        ien_i = 8'hBF; src_pri_i = '0;
        expect_vec(8'h0B); expect_vec(8'h23);
        src_req_i = 6'b010010;
        cyc(3);
        chk(svc_lvl_o == 2'b01, "R5 low level active", svc_lvl_o, 1);
        src_req_i = 6'b010000;
        reti_pulse();
        cyc(3);
        src_req_i = '0;
        reti_pulse();
        cyc(2);
        chk(svc_lvl_o == 2'b00, "R6 released", svc_lvl_o, 0);

        // R5: high-priority preemption of a low routine
        src_pri_i = 6'b100000;
        expect_vec(8'h03);
        src_req_i = 6'b000001;
        cyc(3);
        expect_vec(8'h2B);
        src_req_i = 6'b100001;
        cyc(3);
        chk(svc_lvl_o == 2'b11, "R5 nested levels", svc_lvl_o, 3);
        src_req_i = 6'b101001;
        cyc(3);
        src_req_i = 6'b001001;
        reti_pulse();
        cyc(3);
        chk(svc_lvl_o == 2'b01, "R6 high level popped first", svc_lvl_o, 1);
        expect_vec(8'h1B);
        src_req_i = 6'b001000;
        reti_pulse();
        cyc(3);
        chk(svc_lvl_o == 2'b01, "R5 low taken after release", svc_lvl_o, 1);
        src_req_i = '0;
        reti_pulse();

        // R5: same high level does not preempt
        src_pri_i = 6'b000110;
        expect_vec(8'h13);
        src_req_i = 6'b000100;
        cyc(3);
        chk(svc_lvl_o == 2'b10, "R5 high level active", svc_lvl_o, 2);
        src_req_i = 6'b000110;
        cyc(4);
        expect_vec(8'h0B);
        src_req_i = 6'b000010;
        reti_pulse();
        cyc(3);
        chk(svc_lvl_o == 2'b10, "R5 waiting source taken", svc_lvl_o, 2);
        src_req_i = '0;
        reti_pulse();
        src_pri_i = '0;

        // R4: source enable and global enable
        ien_i = 8'hBE;
        src_req_i = 6'b000001;
        cyc(6);
        ien_i = 8'h3F;
        cyc(6);
        chk(svc_lvl_o == 2'b00, "R4 masked requests not taken", svc_lvl_o, 0);
        expect_vec(8'h03);
        ien_i = 8'hBF;
        cyc(3);
        src_req_i = '0;
        reti_pulse();

        // R7, R8, R10: register access
        byte_wr(8'hA5);
        chk(xr_rdata_o == 8'h85, "R7 byte write, level flag follows pin", xr_rdata_o, 8'h85);
        bit_wr(3'd2, 1'b0);
        chk(xr_rdata_o == 8'h81, "R8 bit clear", xr_rdata_o, 8'h81);
        bit_wr(3'd1, 1'b1);
        chk(xr_rdata_o == 8'h83, "R8 bit set of edge flag", xr_rdata_o, 8'h83);
        bit_wr(3'd1, 1'b0);
        chk(xr_rdata_o == 8'h81, "R8 bit clear of edge flag", xr_rdata_o, 8'h81);
        byte_wr(8'h00);
        chk(xr_rdata_o == 8'h00, "R7 byte write zero", xr_rdata_o, 0);

        // R9: edge mode on pin 2
        byte_wr(8'h01);
        ext2_n_i = 1'b0;
        cyc(4);
        chk(xr_rdata_o == 8'h03, "R9 edge sets flag", xr_rdata_o, 8'h03);
        ext2_n_i = 1'b1;
        expect_vec(8'h33);
        bit_wr(3'd2, 1'b1);
        cyc(3);
        chk(xr_rdata_o == 8'h05, "R9 take clears flag", xr_rdata_o, 8'h05);
        reti_pulse();
        expect_vec(8'h33);
        ext2_n_i = 1'b0;
        cyc(10);
        chk(xr_rdata_o == 8'h05, "R9 held low no retrigger", xr_rdata_o, 8'h05);
        reti_pulse();
        cyc(4);
        ext2_n_i = 1'b1;
        cyc(3);

        // R11: new edge coincides with service clear
        ien_i = 8'h3F;
        ext2_n_i = 1'b0;
        cyc(3);
        ext2_n_i = 1'b1;
        cyc(4);
        chk(xr_rdata_o == 8'h07, "R11 flag pending while masked", xr_rdata_o, 8'h07);
        expect_vec(8'h33); expect_vec(8'h33);
        ext2_n_i = 1'b0;       // next posedge is P
        @(negedge clk);        // after P
        @(negedge clk);        // after P+1, detection window open
        ien_i = 8'hBF;
        @(negedge clk);        // after P+2: take and new edge together
        chk(take_o == 1'b1, "R11 take at coincident edge", take_o, 1);
        chk(xr_rdata_o[1] == 1'b1, "R11 flag kept set", xr_rdata_o[1], 1);
        ext2_n_i = 1'b1;
        cyc(3);
        reti_pulse();
        cyc(3);
        chk(xr_rdata_o == 8'h05, "R11 second take clears flag", xr_rdata_o, 8'h05);
        reti_pulse();

        // R10: level mode on pin 3
        byte_wr(8'h40);
        expect_vec(8'h3B);
        ext3_n_i = 1'b0;
        cyc(4);
        chk(xr_rdata_o == 8'h60, "R10 level flag set", xr_rdata_o, 8'h60);
        chk(svc_lvl_o == 2'b01, "R10 taken at low level", svc_lvl_o, 1);
        expect_vec(8'h3B);
        reti_pulse();
        cyc(3);
        ext3_n_i = 1'b1;
        cyc(4);
        chk(xr_rdata_o == 8'h40, "R10 flag follows pin high", xr_rdata_o, 8'h40);
        reti_pulse();
        cyc(5);
        chk(svc_lvl_o == 2'b00, "R10 no retake after pin high", svc_lvl_o, 0);

        cyc(5);
        chk(exp_q.size() == 0, "R2 all expected takes seen", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule